// File: doc/BRIEF.md
# DRAM Controller Performance Counter Unit

This unit watches a DRAM controller through a vector of one-cycle event pulses and counts those events for software. It has a bank of programmable counters and two dedicated counters. Each programmable counter has a selection mask over the event lines and its own enable bit. A global start command gates the whole bank, and a global end command stops it. The two dedicated counters run on their own. One counts DRAM writes and the other counts DRAM reads. Each has an enable bit and a clear bit of its own, and neither depends on the start and end commands.

Software reaches the unit over a plain 64-bit register bus. A request carries a write flag, a 16-bit address and write data. A read returns its data on the cycle after the request. The counter width, the number of programmable counters and the number of event lines are all parameters. By default there are eight programmable counters, 48-bit counters and 56 event lines.

Top module: `perfmon_unit`

## Requirements
- R1: After reset, every counter value, enable bit and selection mask reads zero. The end-status register at 0x8038 reads zero, and the programmable bank is stopped.
- R2: Programmable counter n is configured at address 0x8040 + 8*n. Bit 63 is the counter's enable. Bits EVT_W-1..0 are its selection mask, where mask bit i watches event line i (event number k uses bit k-1). The register reads back exactly what was written to those bits, and all other bits read as zero.
- R3: A programmable counter adds exactly one on each clock in which three things hold: the bank is running, its enable is set, and at least one event line whose mask bit is set is pulsing. A multi-bit mask, such as four adjacent bits, therefore counts a cycle in which any of its lines fires, and still adds only one.
- R4: Writing bit 0 = 1 to 0x8028 clears every programmable value to zero and sets the bank running. End-status then reads 0. Writing bit 0 = 1 to 0x8030 stops the bank. After that, the programmable values hold through further events, and bit 0 of 0x8038 reads 1.
- R5: A programmable counter stops at its all-ones value and holds it until the next start.
- R6: Free-run enable register 0x80C0: bit 0 enables the write counter and bit 1 enables the read counter. The register reads back these two bits. An enabled counter counts its pulse input whether or not the bank is running. The write count reads at 0x80D0 and the read count reads at 0x80D8.
- R7: A free-run counter wraps from its all-ones value to zero.
- R8: Writing to 0x80C8 issues one-cycle clears. Bit 0 clears the write counter and bit 1 clears the read counter. When a clear and a pulse arrive in the same cycle, the clear wins. The other counter is unaffected, and 0x80C8 reads zero.
- R9: Every read request produces a valid strobe and its data on the following cycle only. Unmapped addresses read zero.
- R10: Writes to any counter value register are ignored.
- R11: Bit 0 of the mode register at 0x8020 selects manual mode, in which counting is governed only by start and end. The bit reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtIn | input | EVT_W | One-cycle event pulses from the controller |
| rdPulse | input | 1 | One pulse per DRAM read |
| wrPulse | input | 1 | One pulse per DRAM write |
| regReq | input | 1 | Register access request |
| regWe | input | 1 | 1 for a write, 0 for a read |
| regAddr | input | 16 | Byte address of the register |
| regWdata | input | 64 | Write data |
| regRvalid | output | 1 | Read data valid, one cycle after a read request |
| regRdata | output | 64 | Read data |

## Verification
The programmable bank is driven with a stream that fires two event lines per cycle, with positions that move from cycle to cycle. Against this stream, counters with single-bit masks, a four-bit group mask and a disabled counter show apart three cases: OR-matching across a mask, one count per cycle, and the per-counter enable. A long run on a single line reaches the saturation limit. The same run shows that a neighbouring counter with no matching traffic stays at zero. The free-run counters get unequal read and write traffic under partial enables, a run past the wrap point, and a clear that coincides with a pulse. Together these show that the two counters stay independent, that each wraps, and that the clear takes priority.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 64;

  localparam logic [ADDR_W-1:0] MODE_ADDR   = 16'h8020;
  localparam logic [ADDR_W-1:0] START_ADDR  = 16'h8028;
  localparam logic [ADDR_W-1:0] STOP_ADDR   = 16'h8030;
  localparam logic [ADDR_W-1:0] STATUS_ADDR = 16'h8038;
  localparam int               CFG_BASE    = 'h8040;
  localparam int               VAL_BASE    = 'h8080;
  localparam logic [ADDR_W-1:0] FREN_ADDR   = 16'h80C0;
  localparam logic [ADDR_W-1:0] FRCLR_ADDR  = 16'h80C8;
  localparam logic [ADDR_W-1:0] FRWR_ADDR   = 16'h80D0;
  localparam logic [ADDR_W-1:0] FRRD_ADDR   = 16'h80D8;

  // One-cycle strobes from control to datapath
  typedef struct packed {
    logic clrProg;
    logic frClrRd;
    logic frClrWr;
  } ctlStrobe_t;
endpackage

// File: rtl/perfmon_ctrl.sv
module perfmon_ctrl
  import perfmon_pkg::*;
#(
  parameter int NUM_PROG = 8,
  parameter int EVT_W    = 56,
  parameter int CNT_W    = 48
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           regReq,
  input  logic                           regWe,
  input  logic [ADDR_W-1:0]              regAddr,
  input  logic [DATA_W-1:0]              regWdata,
  output logic                           regRvalid,
  output logic [DATA_W-1:0]              regRdata,
  input  logic [NUM_PROG-1:0][CNT_W-1:0] progVal,
  input  logic [CNT_W-1:0]               frWrVal,
  input  logic [CNT_W-1:0]               frRdVal,
  output ctlStrobe_t                     strobe,
  output logic                           running,
  output logic [NUM_PROG-1:0]            progEn,
  output logic [NUM_PROG-1:0][EVT_W-1:0] bitmap,
  output logic [1:0]                     frEn
);
  localparam int PAD_CNT = DATA_W - CNT_W;
  localparam int PAD_CFG = DATA_W - 1 - EVT_W;

  logic wrHit, rdHit, startCmd, stopCmd;
  logic ended, modeManual;
  logic [NUM_PROG-1:0] cfgSel;
  logic [DATA_W-1:0] rdNext;

  assign wrHit    = regReq && regWe;
  assign rdHit    = regReq && !regWe;
  assign startCmd = wrHit && (regAddr == START_ADDR) && regWdata[0];
  assign stopCmd  = wrHit && (regAddr == STOP_ADDR) && regWdata[0];

  always_comb begin
    strobe.clrProg = startCmd;
    strobe.frClrWr = wrHit && (regAddr == FRCLR_ADDR) && regWdata[0];
    strobe.frClrRd = wrHit && (regAddr == FRCLR_ADDR) && regWdata[1];
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_PROG; gi++) begin : gCfg
      assign cfgSel[gi] = wrHit && (regAddr == ADDR_W'(CFG_BASE + 8 * gi));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          progEn[gi] <= 1'b0;
          bitmap[gi] <= '0;
        end else if (cfgSel[gi]) begin
          progEn[gi] <= regWdata[DATA_W-1];
          bitmap[gi] <= regWdata[EVT_W-1:0];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running    <= 1'b0;
      ended      <= 1'b0;
      modeManual <= 1'b0;
      frEn       <= 2'b00;
    end else begin
      if (startCmd) begin
        running <= 1'b1;
        ended   <= 1'b0;
      end else if (stopCmd) begin
        running <= 1'b0;
        ended   <= 1'b1;
      end
      if (wrHit && regAddr == MODE_ADDR) modeManual <= regWdata[0];
      if (wrHit && regAddr == FREN_ADDR) frEn <= regWdata[1:0];
    end
  end

  always_comb begin
    rdNext = '0;
    if (regAddr == MODE_ADDR)   rdNext = {{(DATA_W-1){1'b0}}, modeManual};
    if (regAddr == STATUS_ADDR) rdNext = {{(DATA_W-1){1'b0}}, ended};
    if (regAddr == FREN_ADDR)   rdNext = {{(DATA_W-2){1'b0}}, frEn};
    if (regAddr == FRWR_ADDR)   rdNext = {{PAD_CNT{1'b0}}, frWrVal};
    if (regAddr == FRRD_ADDR)   rdNext = {{PAD_CNT{1'b0}}, frRdVal};
    for (int n = 0; n < NUM_PROG; n++) begin
      if (regAddr == ADDR_W'(CFG_BASE + 8 * n))
        rdNext = {progEn[n], {PAD_CFG{1'b0}}, bitmap[n]};
      if (regAddr == ADDR_W'(VAL_BASE + 8 * n))
        rdNext = {{PAD_CNT{1'b0}}, progVal[n]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regRvalid <= 1'b0;
      regRdata  <= '0;
    end else begin
      regRvalid <= rdHit;
      regRdata  <= rdHit ? rdNext : '0;
    end
  end

  // R9: valid strobe follows a read request by exactly one cycle
  assert_rvalid_follows_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regReq && !regWe) |=> regRvalid);
  assert_rvalid_only_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(regReq && !regWe) |=> !regRvalid);
  // R4: start command from the bus leaves the bank running, not ended
  assert_start_runs_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regReq && regWe && regAddr == START_ADDR && regWdata[0]) |=> (running && !ended));
  assert_run_end_excl_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(running && ended));
endmodule

// File: rtl/perfmon_datapath.sv
module perfmon_datapath
  import perfmon_pkg::*;
#(
  parameter int NUM_PROG = 8,
  parameter int EVT_W    = 56,
  parameter int CNT_W    = 48
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ctlStrobe_t                     strobe,
  input  logic                           running,
  input  logic [NUM_PROG-1:0]            progEn,
  input  logic [NUM_PROG-1:0][EVT_W-1:0] bitmap,
  input  logic [1:0]                     frEn,
  input  logic [EVT_W-1:0]               evtIn,
  input  logic                           rdPulse,
  input  logic                           wrPulse,
  output logic [NUM_PROG-1:0][CNT_W-1:0] progVal,
  output logic [CNT_W-1:0]               frWrVal,
  output logic [CNT_W-1:0]               frRdVal
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  genvar gi;
  generate
    for (gi = 0; gi < NUM_PROG; gi++) begin : gProg
      logic hit, inc;
      assign hit = |(evtIn & bitmap[gi]);
      assign inc = running && progEn[gi] && hit && (progVal[gi] != CNT_MAX);

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)               progVal[gi] <= '0;
        else if (strobe.clrProg) progVal[gi] <= '0;
        else if (inc)            progVal[gi] <= progVal[gi] + CNT_ONE;
      end

      // R5: saturated value holds until a start clears it
      assert_sat_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
        (progVal[gi] == CNT_MAX && !strobe.clrProg) |=> progVal[gi] == CNT_MAX);
      // R4: a stopped bank keeps its values
      assert_stop_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
        (!running && !strobe.clrProg) |=> $stable(progVal[gi]));
      // R3: at most one count per cycle
      assert_single_step_R3: assert property (@(posedge clk) disable iff (!rstN)
        !strobe.clrProg |=> (progVal[gi] == $past(progVal[gi]) ||
                             progVal[gi] == $past(progVal[gi]) + CNT_ONE));
    end
  endgenerate

  logic [1:0]            frPulse, frClr;
  logic [1:0][CNT_W-1:0] frVal;
  assign frPulse = {rdPulse, wrPulse};
  assign frClr   = {strobe.frClrRd, strobe.frClrWr};

  generate
    for (gi = 0; gi < 2; gi++) begin : gFree
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                        frVal[gi] <= '0;
        else if (frClr[gi])               frVal[gi] <= '0;
        else if (frEn[gi] && frPulse[gi]) frVal[gi] <= frVal[gi] + CNT_ONE;
      end

      // R8: clear has priority over a coincident pulse
      assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
        frClr[gi] |=> frVal[gi] == '0);
      // R6: a disabled free-run counter does not move
      assert_fr_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
        (!frEn[gi] && !frClr[gi]) |=> $stable(frVal[gi]));
    end
  endgenerate

  assign frWrVal = frVal[0];
  assign frRdVal = frVal[1];
endmodule

// File: rtl/perfmon_unit.sv
module perfmon_unit
  import perfmon_pkg::*;
#(
  parameter int NUM_PROG = 8,
  parameter int EVT_W    = 56,
  parameter int CNT_W    = 48
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [EVT_W-1:0]  evtIn,
  input  logic              rdPulse,
  input  logic              wrPulse,
  input  logic              regReq,
  input  logic              regWe,
  input  logic [15:0]       regAddr,
  input  logic [63:0]       regWdata,
  output logic              regRvalid,
  output logic [63:0]       regRdata
);
  ctlStrobe_t                     strobe;
  logic                           running;
  logic [NUM_PROG-1:0]            progEn;
  logic [NUM_PROG-1:0][EVT_W-1:0] bitmap;
  logic [1:0]                     frEn;
  logic [NUM_PROG-1:0][CNT_W-1:0] progVal;
  logic [CNT_W-1:0]               frWrVal, frRdVal;

  perfmon_ctrl #(.NUM_PROG(NUM_PROG), .EVT_W(EVT_W), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .regReq(regReq), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRvalid(regRvalid), .regRdata(regRdata),
    .progVal(progVal), .frWrVal(frWrVal), .frRdVal(frRdVal), .strobe(strobe),
    .running(running), .progEn(progEn), .bitmap(bitmap), .frEn(frEn));

  perfmon_datapath #(.NUM_PROG(NUM_PROG), .EVT_W(EVT_W), .CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .running(running), .progEn(progEn),
    .bitmap(bitmap), .frEn(frEn), .evtIn(evtIn), .rdPulse(rdPulse), .wrPulse(wrPulse),
    .progVal(progVal), .frWrVal(frWrVal), .frRdVal(frRdVal));
endmodule

// File: tb/tb_perfmon_unit.sv
`timescale 1ns/1ps
module tb_perfmon_unit;
  localparam int NP = 8;
  localparam int EW = 56;
  localparam int CW = 8;
  localparam int SWEEP = 60;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [EW-1:0] evtIn = '0;
  logic rdPulse = 1'b0, wrPulse = 1'b0;
  logic regReq = 1'b0, regWe = 1'b0;
  logic [15:0] regAddr = '0;
  logic [63:0] regWdata = '0;
  logic regRvalid;
  logic [63:0] regRdata;

  int errors = 0;
  int checks = 0;
  logic [EW-1:0] bm [NP];
  logic          en [NP];
  int            expCnt [NP];
  logic [63:0]   rv;

  always #2.5 clk = ~clk;

  perfmon_unit #(.NUM_PROG(NP), .EVT_W(EW), .CNT_W(CW)) dut (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .rdPulse(rdPulse), .wrPulse(wrPulse),
    .regReq(regReq), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRvalid(regRvalid), .regRdata(regRdata));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [63:0] d);
    @(negedge clk); regReq = 1; regWe = 1; regAddr = a; regWdata = d;
    @(negedge clk); regReq = 0; regWe = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [63:0] d);
    @(negedge clk); regReq = 1; regWe = 0; regAddr = a;
    @(negedge clk); regReq = 0; d = regRdata;
  endtask

  function automatic logic [EW-1:0] pat(input int c);
    logic [EW-1:0] p = '0;
    p[c % EW] = 1'b1;
    p[(c * 3 + 5) % EW] = 1'b1;
    return p;
  endfunction

  task automatic runPattern(input int cycles);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk); evtIn = pat(c);
    end
    @(negedge clk); evtIn = '0;
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: act=hung exp=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    rd(16'h8038, rv); check("R1 status", rv, 0);
    rd(16'h8040, rv); check("R1 cfg0", rv, 0);
    rd(16'h8080, rv); check("R1 val0", rv, 0);
    rd(16'h80C0, rv); check("R1 fren", rv, 0);
    rd(16'h80D8, rv); check("R1 frrd", rv, 0);

    // R11: mode register
    wr(16'h8020, 64'h1); rd(16'h8020, rv); check("R11 mode", rv, 1);

    // R2: configure every counter
    for (int n = 0; n < NP; n++) begin
      bm[n] = '0; en[n] = 1'b1;
      if (n < 6) bm[n][(n * 9 + 2) % EW] = 1'b1;
      if (n == 6) begin bm[n][0] = 1'b1; bm[n][30] = 1'b1; en[n] = 1'b0; end
      if (n == 7) bm[n][29:26] = 4'hF;  // event 27 group
      wr(16'(16'h8040 + 8 * n), {en[n], 7'b0, bm[n]});
      rd(16'(16'h8040 + 8 * n), rv);
      check($sformatf("R2 cfg%0d", n), rv, {en[n], 7'b0, bm[n]});
    end

    // R3: sweep with moving two-line pattern
    for (int n = 0; n < NP; n++) begin
      expCnt[n] = 0;
      for (int c = 0; c < SWEEP; c++)
        if (en[n] && ((pat(c) & bm[n]) != '0)) expCnt[n]++;
    end
    wr(16'h8028, 64'h1);
    rd(16'h8038, rv); check("R4 status after start", rv, 0);
    runPattern(SWEEP);
    wr(16'h8030, 64'h1);
    for (int n = 0; n < NP; n++) begin
      rd(16'(16'h8080 + 8 * n), rv);
      check($sformatf("R3 count%0d", n), rv, 64'(expCnt[n]));
    end

    // R4: stopped bank holds, status set, restart clears
    runPattern(20);
    rd(16'h8038, rv); check("R4 status after end", rv, 1);
    for (int n = 0; n < NP; n++) begin
      rd(16'(16'h8080 + 8 * n), rv);
      check($sformatf("R4 hold%0d", n), rv, 64'(expCnt[n]));
    end
    // R10: value register writes ignored
    wr(16'h8080, 64'hFF); rd(16'h8080, rv); check("R10 prog val write", rv, 64'(expCnt[0]));

    wr(16'h8028, 64'h1);
    rd(16'h8098, rv); check("R4 cleared on start", rv, 0);

    // R5: saturation
    wr(16'h8040, {1'b1, 63'h1});
    @(negedge clk); evtIn = '0; evtIn[0] = 1'b1;
    repeat (300) @(negedge clk);
    evtIn = '0;
    wr(16'h8030, 64'h1);
    rd(16'h8080, rv); check("R5 saturate", rv, 64'hFF);
    rd(16'h8088, rv); check("R5 idle neighbour", rv, 0);

    // R6: free-run enables
    wr(16'h80C0, 64'h1);
    rd(16'h80C0, rv); check("R6 fren readback", rv, 1);
    @(negedge clk); wrPulse = 1; rdPulse = 1;
    repeat (10) @(negedge clk);
    wrPulse = 0; rdPulse = 0;
    rd(16'h80D0, rv); check("R6 wr count", rv, 10);
    rd(16'h80D8, rv); check("R6 rd disabled", rv, 0);
    wr(16'h80C0, 64'h3);
    @(negedge clk); rdPulse = 1;
    repeat (5) @(negedge clk);
    rdPulse = 0;
    rd(16'h80D8, rv); check("R6 rd count", rv, 5);
    rd(16'h80D0, rv); check("R6 wr unchanged", rv, 10);
    // R10: free-run value write ignored
    wr(16'h80D0, 64'h0); rd(16'h80D0, rv); check("R10 fr val write", rv, 10);

    // R7: wrap
    @(negedge clk); wrPulse = 1;
    repeat (250) @(negedge clk);
    wrPulse = 0;
    rd(16'h80D0, rv); check("R7 wrap", rv, (10 + 250) % 256);

    // R8: clear coincident with pulse
    @(negedge clk); wrPulse = 1; regReq = 1; regWe = 1; regAddr = 16'h80C8; regWdata = 64'h1;
    @(negedge clk); wrPulse = 0; regReq = 0; regWe = 0;
    rd(16'h80D0, rv); check("R8 clear wins", rv, 0);
    rd(16'h80D8, rv); check("R8 other kept", rv, 5);
    rd(16'h80C8, rv); check("R8 ctrl reads zero", rv, 0);
    wr(16'h80C8, 64'h2);
    rd(16'h80D8, rv); check("R8 rd clear", rv, 0);

    // R9: unmapped read and valid timing
    @(negedge clk); regReq = 1; regWe = 0; regAddr = 16'h1234;
    @(negedge clk); regReq = 0;
    check("R9 valid", {63'b0, regRvalid}, 1);
    check("R9 unmapped zero", regRdata, 0);
    @(negedge clk);
    check("R9 valid drops", {63'b0, regRvalid}, 0);

    finishRun();
  end
endmodule